// File: doc/BRIEF.md
# Universal Bus Register Transceiver

This block is a two-way register stage between an A bus and a B bus, split into two independent halves of `GRP_W` bits (18 by default). Each half carries an A-to-B path and a B-to-A path. Every path owns one storage word and three controls: a level-sensitive latch enable, an edge-sensitive capture strobe, and an output enable. With the latch enable high, the storage follows the input. When the latch enable goes low, the storage keeps the last value it sampled. While the latch enable is low, a rising edge on the strobe loads a new value.

Everything is synchronous to one system clock. The controls and the data are registered once on entry. The strobe edge is found by comparing the registered strobe with its value one cycle earlier. Each output is a registered data word plus a registered drive flag. A cleared drive flag means high impedance, and the data word is then held at zero. The A-to-B enable is active high. The B-to-A enable is active low. To use the block as one 36-bit path, tie the controls of the two halves together.

Top module: `ubx_transceiver`

## Requirements
- R1: While reset is high, every storage word is cleared and every output data word and drive flag is zero, whatever level is on the enable inputs. This holds even with `ab_oe` high or `ba_oe_n` low.
- R2: With a path's latch enable high, its output shows the input value applied before clock edge k once clock edge k+1 has passed (two-edge latency).
- R3: After the latch enable falls, the storage keeps the value sampled in the last cycle the latch enable was high, even if the input changes.
- R4: With the latch enable low, a strobe that was sampled low and is now sampled high loads the current input into storage.
- R5: With the latch enable low and the strobe steady at either level, the storage and the output do not change.
- R6: `ab_oe[g]` = 1 enables drive of `b_out` for group g. `ba_oe_n[g]` = 0 enables drive of `a_out` for group g.
- R7: A disabled output shows drive flag 0 and data 0. The storage still loads, holds and captures while the output is disabled, and re-enabling the output shows the stored word.
- R8: Group g uses control bit g and data bits [GRP_W*g+GRP_W-1 : GRP_W*g]. Activity in one group leaves the other unchanged, and identical controls on both groups give one full-width path.
- R9: When the latch enable is high in the same cycle as a strobe rising edge, the stored value is the live input.
- R10: A strobe held high through reset is not taken as a rising edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | GROUPS*GRP_W | A-side data into the A-to-B paths |
| ab_le | input | GROUPS | A-to-B latch enable per group |
| ab_stb | input | GROUPS | A-to-B capture strobe per group |
| ab_oe | input | GROUPS | A-to-B output enable per group, active high |
| b_out | output | GROUPS*GRP_W | B-side data, zero when not driven |
| b_drv | output | GROUPS | B-side drive flag per group |
| b_in | input | GROUPS*GRP_W | B-side data into the B-to-A paths |
| ba_le | input | GROUPS | B-to-A latch enable per group |
| ba_stb | input | GROUPS | B-to-A capture strobe per group |
| ba_oe_n | input | GROUPS | B-to-A output enable per group, active low |
| a_out | output | GROUPS*GRP_W | A-side data, zero when not driven |
| a_drv | output | GROUPS | A-side drive flag per group |

## Verification
The assertions check four rules on every cycle, using the registered control stage:
- a transparent cycle loads the sampled input;
- a strobe edge with the latch enable low loads the sampled input;
- with neither condition, the storage word stays stable;
- an undriven output reads zero, and a driven output matches the storage.

They also check that a detected edge never repeats in the next cycle. The bench scenarios cover the rest: reset with active enables, the value kept after a latch-enable fall, captures made while the output is disabled, the independence of the two halves, the enable polarity of each direction, and a strobe held high through reset.

// File: rtl/ubx_pkg.sv
package ubx_pkg;
  localparam int UBX_GRP_W  = 18;
  localparam int UBX_GROUPS = 2;

  typedef enum logic [1:0] {
    UBX_HOLD    = 2'd0,
    UBX_FOLLOW  = 2'd1,
    UBX_CAPTURE = 2'd2
  } ubx_mode_e;

  function automatic ubx_mode_e ubx_pick_mode(input logic le, input logic rise);
    if (le)        return UBX_FOLLOW;
    else if (rise) return UBX_CAPTURE;
    else           return UBX_HOLD;
  endfunction
endpackage

// File: rtl/ubx_ctl_sync.sv
module ubx_ctl_sync #(
  parameter bit OE_ACTIVE_LOW = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic le_raw,
  input  logic stb_raw,
  input  logic oe_raw,
  output logic le_s,
  output logic stb_rise,
  output logic oe_s
);
  logic stb_s, stb_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      le_s  <= 1'b0;
      stb_s <= 1'b1;
      stb_d <= 1'b1;
      oe_s  <= 1'b0;
    end else begin
      le_s  <= le_raw;
      stb_s <= stb_raw;
      stb_d <= stb_s;
      oe_s  <= OE_ACTIVE_LOW ? ~oe_raw : oe_raw;
    end
  end

  assign stb_rise = stb_s & ~stb_d;

  // R4
  edge_once_chk: assert property (@(posedge clk) disable iff (rst)
    stb_rise |=> !stb_rise);
endmodule

// File: rtl/ubx_store_path.sv
module ubx_store_path
  import ubx_pkg::*;
#(
  parameter int W = UBX_GRP_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_raw,
  input  logic         le_s,
  input  logic         stb_rise,
  input  logic         oe_s,
  output logic [W-1:0] q_data,
  output logic         q_drv
);
  logic [W-1:0] d_s, word_q, word_nx;
  ubx_mode_e    mode;

  always_comb begin
    mode = ubx_pick_mode(le_s, stb_rise);
    unique case (mode)
      UBX_FOLLOW, UBX_CAPTURE: word_nx = d_s;
      default:                 word_nx = word_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      d_s    <= '0;
      word_q <= '0;
      q_data <= '0;
      q_drv  <= 1'b0;
    end else begin
      d_s    <= d_raw;
      word_q <= word_nx;
      q_data <= oe_s ? word_nx : '0;
      q_drv  <= oe_s;
    end
  end

  // R2
  follow_load_chk: assert property (@(posedge clk) disable iff (rst)
    le_s |=> word_q == $past(d_s));
  // R4
  edge_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!le_s && stb_rise) |=> word_q == $past(d_s));
  // R5
  steady_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!le_s && !stb_rise) |=> $stable(word_q));
  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !q_drv |-> q_data == '0);
  // R7
  drive_match_chk: assert property (@(posedge clk) disable iff (rst)
    q_drv |-> q_data == word_q);
endmodule

// File: rtl/ubx_half.sv
module ubx_half
  import ubx_pkg::*;
#(
  parameter int W = UBX_GRP_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic         ab_le,
  input  logic         ab_stb,
  input  logic         ab_oe,
  output logic [W-1:0] b_out,
  output logic         b_drv,
  input  logic [W-1:0] b_in,
  input  logic         ba_le,
  input  logic         ba_stb,
  input  logic         ba_oe_n,
  output logic [W-1:0] a_out,
  output logic         a_drv
);
  logic ab_le_s, ab_rise, ab_oe_s;
  logic ba_le_s, ba_rise, ba_oe_s;

  ubx_ctl_sync #(.OE_ACTIVE_LOW(1'b0)) u_ab_ctl (
    .clk(clk), .rst(rst), .le_raw(ab_le), .stb_raw(ab_stb), .oe_raw(ab_oe),
    .le_s(ab_le_s), .stb_rise(ab_rise), .oe_s(ab_oe_s));

  ubx_ctl_sync #(.OE_ACTIVE_LOW(1'b1)) u_ba_ctl (
    .clk(clk), .rst(rst), .le_raw(ba_le), .stb_raw(ba_stb), .oe_raw(ba_oe_n),
    .le_s(ba_le_s), .stb_rise(ba_rise), .oe_s(ba_oe_s));

  ubx_store_path #(.W(W)) u_ab_path (
    .clk(clk), .rst(rst), .d_raw(a_in), .le_s(ab_le_s), .stb_rise(ab_rise),
    .oe_s(ab_oe_s), .q_data(b_out), .q_drv(b_drv));

  ubx_store_path #(.W(W)) u_ba_path (
    .clk(clk), .rst(rst), .d_raw(b_in), .le_s(ba_le_s), .stb_rise(ba_rise),
    .oe_s(ba_oe_s), .q_data(a_out), .q_drv(a_drv));
endmodule

// File: rtl/ubx_transceiver.sv
module ubx_transceiver
  import ubx_pkg::*;
#(
  parameter int GRP_W  = UBX_GRP_W,
  parameter int GROUPS = UBX_GROUPS,
  localparam int BUS_W = GRP_W * GROUPS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_W-1:0]  a_in,
  input  logic [GROUPS-1:0] ab_le,
  input  logic [GROUPS-1:0] ab_stb,
  input  logic [GROUPS-1:0] ab_oe,
  output logic [BUS_W-1:0]  b_out,
  output logic [GROUPS-1:0] b_drv,
  input  logic [BUS_W-1:0]  b_in,
  input  logic [GROUPS-1:0] ba_le,
  input  logic [GROUPS-1:0] ba_stb,
  input  logic [GROUPS-1:0] ba_oe_n,
  output logic [BUS_W-1:0]  a_out,
  output logic [GROUPS-1:0] a_drv
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_half
    ubx_half #(.W(GRP_W)) u_half (
      .clk    (clk),
      .rst    (rst),
      .a_in   (a_in[g*GRP_W +: GRP_W]),
      .ab_le  (ab_le[g]),
      .ab_stb (ab_stb[g]),
      .ab_oe  (ab_oe[g]),
      .b_out  (b_out[g*GRP_W +: GRP_W]),
      .b_drv  (b_drv[g]),
      .b_in   (b_in[g*GRP_W +: GRP_W]),
      .ba_le  (ba_le[g]),
      .ba_stb (ba_stb[g]),
      .ba_oe_n(ba_oe_n[g]),
      .a_out  (a_out[g*GRP_W +: GRP_W]),
      .a_drv  (a_drv[g])
    );
  end

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (b_drv == '0 && a_drv == '0 && b_out == '0 && a_out == '0));
endmodule

// File: tb/ubx_transceiver_test.sv
`timescale 1ns/1ps
module ubx_transceiver_test;
  localparam int W  = 18;
  localparam int G  = 2;
  localparam int BW = W * G;
  localparam int NV = 14;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [BW-1:0] a_in = '0, b_in = '0;
  logic [G-1:0]  ab_le = '0, ab_stb = '0, ab_oe = '0;
  logic [G-1:0]  ba_le = '0, ba_stb = '0, ba_oe_n = '1;
  logic [BW-1:0] b_out, a_out;
  logic [G-1:0]  b_drv, a_drv;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  ubx_transceiver #(.GRP_W(W), .GROUPS(G)) uut (
    .clk(clk), .rst(rst),
    .a_in(a_in), .ab_le(ab_le), .ab_stb(ab_stb), .ab_oe(ab_oe),
    .b_out(b_out), .b_drv(b_drv),
    .b_in(b_in), .ba_le(ba_le), .ba_stb(ba_stb), .ba_oe_n(ba_oe_n),
    .a_out(a_out), .a_drv(a_drv));

  // {le, stb, oe, din[17:0], exp_drv, exp_data[17:0]} for group 0 A-to-B
  localparam logic [39:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b1, 18'h12345, 1'b1, 18'h12345},  // R2
    {1'b1, 1'b0, 1'b1, 18'h0ABCD, 1'b1, 18'h0ABCD},  // R2
    {1'b0, 1'b0, 1'b1, 18'h3FFFF, 1'b1, 18'h0ABCD},  // R3
    {1'b0, 1'b0, 1'b1, 18'h11111, 1'b1, 18'h0ABCD},  // R5
    {1'b0, 1'b1, 1'b1, 18'h22222, 1'b1, 18'h22222},  // R4
    {1'b0, 1'b1, 1'b1, 18'h33333, 1'b1, 18'h22222},  // R5
    {1'b0, 1'b0, 1'b1, 18'h04444, 1'b1, 18'h22222},  // R5
    {1'b0, 1'b0, 1'b0, 18'h05555, 1'b0, 18'h00000},  // R7
    {1'b0, 1'b1, 1'b0, 18'h06666, 1'b0, 18'h00000},  // R7
    {1'b0, 1'b1, 1'b1, 18'h07777, 1'b1, 18'h06666},  // R7
    {1'b1, 1'b0, 1'b0, 18'h18888, 1'b0, 18'h00000},  // R7
    {1'b0, 1'b0, 1'b1, 18'h29999, 1'b1, 18'h18888},  // R3
    {1'b1, 1'b1, 1'b1, 18'h2AAAA, 1'b1, 18'h2AAAA},  // R9
    {1'b0, 1'b0, 1'b1, 18'h00000, 1'b1, 18'h2AAAA}   // R5
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    // R1: reset with every enable active and transparent data
    @(negedge clk);
    rst = 1'b1; ab_le = '1; ab_oe = '1; ba_le = '1; ba_oe_n = '0;
    a_in = 36'hF_FFFF_FFFF; b_in = 36'hA_AAAA_AAAA;
    step(3);
    check("R1 b_drv", BW'(b_drv), '0);
    check("R1 b_out", b_out, '0);
    check("R1 a_drv", BW'(a_drv), '0);
    check("R1 a_out", a_out, '0);

    // R10: strobe held high through reset, latch enable low
    ab_le = '0; ab_stb = '1; ab_oe = '1; ba_le = '0; ba_oe_n = '1;
    step(2);
    rst = 1'b0;
    step(3);
    check("R10 no capture", b_out, '0);
    check("R10 drive on", BW'(b_drv), BW'(2'b11));
    ab_stb = '0; step(2);
    ab_stb = '1; step(2);
    check("R4 first edge after reset", b_out, 36'hF_FFFF_FFFF);

    // R8: latch group 1 at a known word before the group 0 table
    ab_stb = '0; ab_le = 2'b10; ab_oe = 2'b11;
    a_in[35:18] = 18'h15A5A; step(2);
    ab_le = 2'b00; step(2);
    a_in[35:18] = 18'h0F0F0;

    for (int i = 0; i < NV; i++) begin
      ab_le[0]   = VEC[i][39];
      ab_stb[0]  = VEC[i][38];
      ab_oe[0]   = VEC[i][37];
      a_in[17:0] = VEC[i][36:19];
      step(2);
      check($sformatf("vec%0d drv", i), BW'(b_drv[0]), BW'(VEC[i][18]));
      check($sformatf("vec%0d data", i), BW'(b_out[17:0]), BW'(VEC[i][17:0]));
    end
    check("R8 group1 held", BW'(b_out[35:18]), BW'(18'h15A5A));
    check("R8 group1 drive", BW'(b_drv[1]), BW'(1'b1));

    // R6: B-to-A enable is active low
    ba_le = 2'b11; ba_stb = '0; ba_oe_n = 2'b11; b_in = 36'h9_8765_4321;
    step(2);
    check("R6 ba disabled drv", BW'(a_drv), '0);
    check("R7 ba disabled data", a_out, '0);
    ba_oe_n = 2'b00; step(2);
    check("R6 ba enabled drv", BW'(a_drv), BW'(2'b11));
    check("R2 ba transparent", a_out, 36'h9_8765_4321);
    ba_oe_n = 2'b01; step(2);
    check("R8 ba group split drv", BW'(a_drv), BW'(2'b10));
    check("R8 ba group split data", a_out, {b_in[35:18], 18'h0});

    // R8: both groups driven together as one full-width path
    ab_le = 2'b00; ab_stb = 2'b00; ab_oe = 2'b11; step(2);
    a_in = 36'hA_5C3C_F00F; ab_stb = 2'b11; step(2);
    check("R8 wide capture", b_out, 36'hA_5C3C_F00F);
    a_in = 36'h0; step(2);
    check("R5 wide hold", b_out, 36'hA_5C3C_F00F);

    summary();
  end
endmodule